// File: doc/BRIEF.md
# Upstream Burst Slot Timer

This block picks the clock cycle in which an upstream burst begins. It has two sources for that decision, and a mode input selects between them. In slotted mode a slot counter is cleared by the 3 ms timing marker that the downstream receiver produces. The counter then advances once every programmable number of clocks. The MAC posts a request that holds a target slot number and a propagation compensation value. The burst-start pulse is produced a fixed number of clocks after the target slot begins, and that number follows the compensation value.

In external-pin mode the slot logic does not start bursts. Instead, every change of level on an asynchronous synchronisation pin gives one start pulse. A rising change and a falling change count the same. The pin passes through a two-flop synchroniser before the change is detected.

The current slot number and a request-pending flag are visible to the MAC. A new request always replaces the one that is waiting.

Top module: `us_burst_slot_timer`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `burst_start` is 0, `slot_count` is 0 and `req_pending` is 0.
- R2: A cycle with `mrk_3ms` high makes `slot_count` read 0 in the next cycle. That next cycle is the first cycle of slot 0. Each later slot begins `clks_per_slot` cycles after the previous one. A value of 0 is treated as 1.
- R3: `slot_count` stops at its all-ones value (255 with default widths) and stays there until the next marker. While it is stopped, no new slot begins.
- R4: In slotted mode (`ext_mode` = 0), `burst_start` is high for exactly one cycle. That cycle comes `req_comp` + 1 cycles after the first cycle in which the requested slot is current. The compensation can be longer than a slot.
- R5: `req_pending` rises in the cycle after `req_valid` is sampled high. It falls in the cycle after the requested slot begins.
- R6: A request that is registered in or after the first cycle of its slot does not match that slot. It stays pending and fires in that slot after the next marker.
- R7: A request with `req_valid` high replaces any pending request, including one that matches its slot in the same cycle. The old request still fires on its own schedule.
- R8: In external-pin mode (`ext_mode` = 1), every change of `sync_pin`, rising or falling, gives a one-cycle `burst_start` pulse. The pulse starts at the second rising clock edge after the change. Changes on consecutive cycles give consecutive pulses.
- R9: In external-pin mode, slot matches give no pulse and leave the request pending. In slotted mode, changes on `sync_pin` give no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_mode | input | 1 | 0: slotted mode, 1: external-pin mode |
| clks_per_slot | input | 16 | Clock cycles per upstream slot |
| mrk_3ms | input | 1 | Downstream 3 ms marker strobe |
| req_valid | input | 1 | MAC posts a new request this cycle |
| req_slot | input | 8 | Target slot number of the request |
| req_comp | input | 16 | Propagation compensation, in clocks |
| sync_pin | input | 1 | Asynchronous external sync pin |
| burst_start | output | 1 | One-cycle burst start pulse |
| slot_count | output | 8 | Current slot number |
| req_pending | output | 1 | A request is waiting for its slot |

## Verification
Two functions can fall in the same cycle: a slot-start match that consumes the pending request, and a new MAC request that loads the request registers. The bench provokes this by driving `req_valid` exactly in the cycle where `slot_count` first shows the pending target. Two results are checked. The old request must fire after its compensation as if nothing else had happened. `req_pending` must stay high, and the new request must fire only at the start of its own slot. A second corner drives a request inside the first cycle of its target slot. That request must wait for the next marker period.

// File: rtl/us_slot_pkg.sv
package us_slot_pkg;
  typedef enum logic {
    SRC_SLOTTED = 1'b0,
    SRC_PIN     = 1'b1
  } start_src_e;
endpackage

// File: rtl/us_slot_counter.sv
module us_slot_counter #(
  parameter int SLOT_W = 8,
  parameter int CPS_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              marker,
  input  logic [CPS_W-1:0]  cps,
  output logic [SLOT_W-1:0] slot_cnt,
  output logic              slot_start
);
  localparam logic [SLOT_W-1:0] SLOT_MAX = {SLOT_W{1'b1}};

  logic [CPS_W-1:0]  tick_q, tick_d, tick_last;
  logic [SLOT_W-1:0] slot_q, slot_d;
  logic              fresh_q, fresh_d;

  always_comb tick_last = (cps == '0) ? '0 : cps - 1'b1;

  always_comb begin
    tick_d  = tick_q;
    slot_d  = slot_q;
    fresh_d = 1'b0;
    if (marker) begin
      tick_d  = '0;
      slot_d  = '0;
      fresh_d = 1'b1;
    end else if (tick_q >= tick_last) begin
      tick_d = '0;
      if (slot_q != SLOT_MAX) begin
        slot_d  = slot_q + 1'b1;
        fresh_d = 1'b1;
      end
    end else begin
      tick_d = tick_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q  <= '0;
      slot_q  <= '0;
      fresh_q <= 1'b1;
    end else begin
      tick_q  <= tick_d;
      slot_q  <= slot_d;
      fresh_q <= fresh_d;
    end
  end

  assign slot_cnt   = slot_q;
  assign slot_start = fresh_q;

  // R2: marker clears the count and opens slot 0
  p_marker_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    marker |=> (slot_cnt == '0) && slot_start);

  // R3: count only steps by one or returns to zero
  p_slot_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(slot_cnt) |-> ((slot_cnt == '0) || (slot_cnt == $past(slot_cnt) + 1'b1)));

  // R3: saturated count holds without a marker
  p_sat_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((slot_cnt == SLOT_MAX) && !marker) |=> ((slot_cnt == SLOT_MAX) && !slot_start));
endmodule

// File: rtl/us_pin_toggle_det.sv
module us_pin_toggle_det (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic toggle
);
  logic meta_q, sync_q, last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      last_q <= 1'b0;
    end else begin
      meta_q <= pin;
      sync_q <= meta_q;
      last_q <= sync_q;
    end
  end

  assign toggle = sync_q ^ last_q;
endmodule

// File: rtl/us_burst_sched.sv
module us_burst_sched #(
  parameter int SLOT_W = 8,
  parameter int COMP_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slotted_en,
  input  logic [SLOT_W-1:0] slot_cnt,
  input  logic              slot_start,
  input  logic              req_valid,
  input  logic [SLOT_W-1:0] req_slot,
  input  logic [COMP_W-1:0] req_comp,
  output logic              fire,
  output logic              pending
);
  logic              pend_q, pend_d;
  logic [SLOT_W-1:0] tgt_q, tgt_d;
  logic [COMP_W-1:0] comp_q, comp_d;
  logic              armed_q, armed_d;
  logic [COMP_W-1:0] dly_q, dly_d;
  logic              hit;

  always_comb hit = slotted_en & pend_q & slot_start & (slot_cnt == tgt_q);

  always_comb begin
    pend_d  = pend_q;
    tgt_d   = tgt_q;
    comp_d  = comp_q;
    armed_d = armed_q;
    dly_d   = dly_q;
    if (hit) pend_d = 1'b0;
    if (req_valid) begin
      pend_d = 1'b1;
      tgt_d  = req_slot;
      comp_d = req_comp;
    end
    if (hit) begin
      armed_d = 1'b1;
      dly_d   = comp_q;
    end else if (armed_q) begin
      if (dly_q == '0) armed_d = 1'b0;
      else             dly_d   = dly_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      tgt_q   <= '0;
      comp_q  <= '0;
      armed_q <= 1'b0;
      dly_q   <= '0;
    end else begin
      pend_q  <= pend_d;
      tgt_q   <= tgt_d;
      comp_q  <= comp_d;
      armed_q <= armed_d;
      dly_q   <= dly_d;
    end
  end

  assign fire    = armed_q & (dly_q == '0);
  assign pending = pend_q;

  // R7: a posted request always becomes the pending one
  p_replace_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (pend_q && (tgt_q == $past(req_slot)) && (comp_q == $past(req_comp))));

  // R5: a consumed request leaves nothing pending
  p_pending_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !req_valid) |=> !pend_q);

  // R4: the start pulse lasts a single cycle unless re-armed
  p_fire_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !hit) |=> !fire);

  // R9: pin mode never consumes a pending request
  p_hold_pending_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!slotted_en && pend_q && !req_valid) |=> pend_q);
endmodule

// File: rtl/us_burst_slot_timer.sv
module us_burst_slot_timer #(
  parameter int SLOT_W = 8,
  parameter int CPS_W  = 16,
  parameter int COMP_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_mode,
  input  logic [CPS_W-1:0]  clks_per_slot,
  input  logic              mrk_3ms,
  input  logic              req_valid,
  input  logic [SLOT_W-1:0] req_slot,
  input  logic [COMP_W-1:0] req_comp,
  input  logic              sync_pin,
  output logic              burst_start,
  output logic [SLOT_W-1:0] slot_count,
  output logic              req_pending
);
  import us_slot_pkg::*;

  start_src_e        src;
  logic [SLOT_W-1:0] slot_cnt;
  logic              slot_start;
  logic              sched_fire;
  logic              pin_toggle;

  assign src = start_src_e'(ext_mode);

  us_slot_counter #(.SLOT_W(SLOT_W), .CPS_W(CPS_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .marker     (mrk_3ms),
    .cps        (clks_per_slot),
    .slot_cnt   (slot_cnt),
    .slot_start (slot_start)
  );

  us_burst_sched #(.SLOT_W(SLOT_W), .COMP_W(COMP_W)) u_sched (
    .clk        (clk),
    .rst_n      (rst_n),
    .slotted_en (src == SRC_SLOTTED),
    .slot_cnt   (slot_cnt),
    .slot_start (slot_start),
    .req_valid  (req_valid),
    .req_slot   (req_slot),
    .req_comp   (req_comp),
    .fire       (sched_fire),
    .pending    (req_pending)
  );

  us_pin_toggle_det u_pin (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin    (sync_pin),
    .toggle (pin_toggle)
  );

  assign burst_start = (src == SRC_PIN) ? pin_toggle : sched_fire;
  assign slot_count  = slot_cnt;
endmodule

// File: tb/tb_us_burst_slot_timer.sv
module tb_us_burst_slot_timer;
  localparam int CLK_PERIOD = 10;
  localparam int SLOT_W     = 8;
  localparam int SLOT_MAX   = (1 << SLOT_W) - 1;
  localparam int WD_LIMIT   = 150000;
  localparam int NEVER      = 1000000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ext_mode;
  logic [15:0] clks_per_slot;
  logic        mrk_3ms;
  logic        req_valid;
  logic [7:0]  req_slot;
  logic [15:0] req_comp;
  logic        sync_pin;
  logic        burst_start;
  logic [7:0]  slot_count;
  logic        req_pending;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  logic d1, d2, d3;

  us_burst_slot_timer dut (
    .clk(clk), .rst_n(rst_n), .ext_mode(ext_mode), .clks_per_slot(clks_per_slot),
    .mrk_3ms(mrk_3ms), .req_valid(req_valid), .req_slot(req_slot), .req_comp(req_comp),
    .sync_pin(sync_pin), .burst_start(burst_start), .slot_count(slot_count),
    .req_pending(req_pending)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc >= WD_LIMIT) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer than %0d", cyc, WD_LIMIT);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  function automatic int exp_slot(input int n, input int cps);
    int s = n / cps;
    return (s > SLOT_MAX) ? SLOT_MAX : s;
  endfunction

  function automatic int fire_at(input int s, input int cps, input int comp);
    return s * cps + comp + 1;
  endfunction

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  // Marker (plus optional request), then per-cycle checks; optional extra request at mid_n
  task automatic run_seq(input int cps, input bit with_req, input int s0, input int c0,
                         input int mid_n, input int s1, input int c1,
                         input int fire_a, input int fire_b,
                         input int pend_from, input int pend_until, input int len,
                         input string tag);
    clks_per_slot = 16'(cps);
    mrk_3ms = 1'b1;
    if (with_req) begin
      req_valid = 1'b1; req_slot = 8'(s0); req_comp = 16'(c0);
    end
    @(negedge clk);
    mrk_3ms = 1'b0; req_valid = 1'b0;
    for (int n = 0; n <= len; n++) begin
      bit eb;
      bit ep;
      eb = (n == fire_a) || (n == fire_b);
      ep = (n >= pend_from) && (n <= pend_until);
      chk(burst_start == eb, {tag, " R4 burst_start"}, int'(burst_start), int'(eb));
      chk(req_pending == ep, {tag, " R5 req_pending"}, int'(req_pending), int'(ep));
      chk(int'(slot_count) == exp_slot(n, cps), {tag, " R2 slot_count"},
          int'(slot_count), exp_slot(n, cps));
      if (n == mid_n) begin
        req_valid = 1'b1; req_slot = 8'(s1); req_comp = 16'(c1);
      end
      @(negedge clk);
      req_valid = 1'b0;
    end
  endtask

  // Drives pin toggles from pat; expected pulse = pin change seen two edges ago
  task automatic pin_run(input bit ext, input logic [31:0] pat, input string tag);
    for (int i = 0; i < 3; i++) @(negedge clk);
    d1 = sync_pin; d2 = sync_pin; d3 = sync_pin;
    for (int i = 0; i < 35; i++) begin
      logic eb;
      logic np;
      eb = ext ? (d2 ^ d3) : 1'b0;
      chk(burst_start == eb, tag, int'(burst_start), int'(eb));
      np = (i < 32 && pat[i]) ? ~sync_pin : sync_pin;
      sync_pin = np;
      d3 = d2; d2 = d1; d1 = np;
      @(negedge clk);
    end
  endtask

  initial begin
    void'($urandom(32'h00C0FFEE));
    rst_n = 1'b0; ext_mode = 1'b0; clks_per_slot = 16'd4; mrk_3ms = 1'b0;
    req_valid = 1'b0; req_slot = '0; req_comp = '0; sync_pin = 1'b0;
    repeat (3) @(negedge clk);
    chk(burst_start == 1'b0, "R1 burst_start in reset", int'(burst_start), 0);
    chk(slot_count == 8'd0, "R1 slot_count in reset", int'(slot_count), 0);
    chk(req_pending == 1'b0, "R1 req_pending in reset", int'(req_pending), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(burst_start == 1'b0, "R1 burst_start after reset", int'(burst_start), 0);
    chk(slot_count == 8'd0, "R1 slot_count after reset", int'(slot_count), 0);
    chk(req_pending == 1'b0, "R1 req_pending after reset", int'(req_pending), 0);

    // R4 directed: slot 2, 4 clocks per slot, compensation 3
    run_seq(4, 1, 2, 3, -1, 0, 0, fire_at(2, 4, 3), -1, 0, 8, fire_at(2, 4, 3) + 4, "dir");
    // R4 zero corner: slot 0, one clock per slot, no compensation
    run_seq(1, 1, 0, 0, -1, 0, 0, fire_at(0, 1, 0), -1, 0, 0, 6, "zero");
    // R4 compensation longer than a slot
    run_seq(2, 1, 1, 7, -1, 0, 0, fire_at(1, 2, 7), -1, 0, 2, fire_at(1, 2, 7) + 3, "longcomp");

    // R4/R5 random profiles
    for (int k = 0; k < 12; k++) begin
      int cps = 1 + int'($urandom % 6);
      int s   = int'($urandom % 6);
      int c   = int'($urandom % 10);
      run_seq(cps, 1, s, c, -1, 0, 0, fire_at(s, cps, c), -1, 0, s * cps,
              fire_at(s, cps, c) + 4, "rand");
    end

    // R7: replace a waiting request before its slot
    run_seq(3, 1, 2, 0, 1, 4, 1, fire_at(4, 3, 1), -1, 0, 12, fire_at(4, 3, 1) + 4, "R7 replace");
    // R7/R5: new request lands in the cycle the old one matches
    run_seq(3, 1, 1, 0, 3, 3, 0, fire_at(1, 3, 0), fire_at(3, 3, 0), 0, 9,
            fire_at(3, 3, 0) + 4, "R7 same-cycle");

    // R6: request posted in the first cycle of its own slot waits a period
    run_seq(2, 0, 0, 0, 4, 2, 1, -1, -1, 5, NEVER, 20, "R6 late");
    run_seq(2, 0, 0, 0, -1, 0, 0, fire_at(2, 2, 1), -1, 0, 4, fire_at(2, 2, 1) + 4, "R6 next");

    // R3: saturation, last slot fires once and never repeats
    run_seq(1, 1, SLOT_MAX, 0, -1, 0, 0, fire_at(SLOT_MAX, 1, 0), -1, 0, SLOT_MAX, 290, "R3 sat");

    // R9: pin mode ignores the slot match; request stays pending
    ext_mode = 1'b1;
    run_seq(2, 1, 1, 0, -1, 0, 0, -1, -1, 0, NEVER, 10, "R9 ext");
    // R8: directed toggles both ways and back-to-back, then random
    pin_run(1'b1, 32'h0000_81C1, "R8 pin directed");
    pin_run(1'b1, $urandom, "R8 pin random");
    chk(req_pending == 1'b1, "R9 request kept in pin mode", int'(req_pending), 1);
    // R9: slotted mode ignores the pin
    ext_mode = 1'b0;
    pin_run(1'b0, $urandom | 32'h1, "R9 pin in slotted mode");
    // R9: held request fires after the next marker
    run_seq(2, 0, 0, 0, -1, 0, 0, fire_at(1, 2, 0), -1, 0, 2, 8, "R9 resume");

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule